// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Deferred Sources

This block gathers level-sensitive interrupt sources into groups and presents one interrupt line per group to a parent interrupt controller. Each group owns 32 source lines, a sticky enable set, a hidden mask, a status word that firmware reads to learn which sources fired, and a hidden deferred set. A source that arrives while its group is idle and unmasked is written straight into the status word, and the group output goes high. A source that arrives while the group is busy or masked is held in the deferred set instead.

Firmware acknowledges sources by writing ones to the status word, which clears those bits. When the status word drains to zero, any deferred sources are moved into it and the output stays high. If nothing is deferred, the output falls. Writing to a group's enable word has two uses. Writing new bits adds them to the sticky enable. Rewriting the same bits masks or unmasks the group, and the bits that changed decide which.

The block sits on a plain 32-bit register port: one write strobe, a byte address, write data, and combinational read data. Every location in the register window that is not an enable or status word is ordinary storage.

Top module: `intc_group_agg`

## Requirements
- R1: After reset every output line is low and every readable location in the window returns 0.
- R2: A group is evaluated only in a cycle where one of its source lines is high and was low in the previous cycle. The selected set is the currently high lines ANDed with the sticky enable. A zero selected set changes nothing.
- R3: When evaluation finds the group's mask zero and its status zero, the status takes the selected set and the group output goes high. The output is high whenever the status is nonzero.
- R4: When evaluation finds the mask or the status nonzero, the selected set is ORed into the deferred set, and the status and output keep their values.
- R5: An enable write ORs the written value into the sticky enable, which software can never clear. When both the written value and the sticky enable are zero, the write only stores the value. When the OR adds bits, the enable word stores the written value and the write does nothing else. Reads return the last written value, not the sticky enable.
- R6: An enable write that adds no bits computes the difference between the stored word and the written value. If any differing bit is set in the written value, those bits are cleared from the mask. Otherwise they are set in the mask. The written value is then stored. Unmasking does not replay deferred sources by itself.
- R7: A status write clears the bits written as 1. A write of 0xFFFFFFFF only clears: the output and the deferred set are untouched.
- R8: Any other status write that leaves the status zero does one of two things. If the deferred set is nonzero, it moves into the status, the deferred set empties, and the output goes or stays high. Otherwise the output goes low.
- R9: Group n (n below NUM_GROUPS) has its enable word at byte 0x1000 + 0x100·n and its status word at 0x1004 + 0x100·n. Address bits [11:8] select the group, and bits [1:0] are ignored.
- R10: Any other address inside the window stores the written word and returns it on reads. Reads have no side effects anywhere.
- R11: Reads at or above the window size (0x2000) return 0. Writes there change nothing, including the locations they would alias to.
- R12: When a register write and a source rise fall in the same cycle, the write is applied first, and the source is evaluated against the state the write leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for one 32-bit word |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_lines | input | NUM_GROUPS·LINES | Level source lines, group n in bits [n·LINES +: LINES] |
| irq_out | output | NUM_GROUPS | One interrupt line per group toward the parent controller |

## Verification
The bench builds the block with its defaults: nine groups of 32 lines, a 16-bit address and a 0x2000-byte window. With these values the last group's words sit at 0x1800/0x1804, and the unused group slots from 0x1900 upward behave as plain storage. The 16-bit address also reaches past the window, so aliased writes above 0x2000 can be tried. Directed sequences cover masking through a rewritten enable, replay after an acknowledge, the all-ones initialisation write, and a same-cycle write and source rise whose result depends on ordering. Random traffic then exercises enable, status, storage and source changes concentrated on a few low lines, so that enabled and arriving sources overlap often.

// File: rtl/intc_agg_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the grouped interrupt aggregator.
// Assumes a 32-bit register port; group words live in a fixed 0x1000 region.
package intc_agg_pkg;

    localparam int unsigned REG_W       = 32;
    localparam logic [REG_W-1:0] INIT_WORD = '1;
    localparam logic [31:0] GRP_BASE    = 32'h0000_1000;
    localparam logic [31:0] GRP_STRIDE  = 32'h0000_0100;
    localparam int unsigned GRP_IDX_LSB = 8;
    localparam int unsigned GRP_IDX_W   = 4;

    // Kind of location an address selects.
    typedef enum logic [1:0] {
        AK_VOID   = 2'd0,
        AK_PLAIN  = 2'd1,
        AK_ENABLE = 2'd2,
        AK_STATUS = 2'd3
    } addr_kind_e;

endpackage

// File: rtl/intc_addr_decode.sv
`timescale 1ns/1ps
// Address decoder: classifies a byte address as out of window, plain storage,
// a group enable word or a group status word, and extracts the word and group
// indices. Assumes the window covers the group region (0x1000 + 16*0x100).
module intc_addr_decode
    import intc_agg_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned WINDOW_BYTES = 32'h2000,
    parameter int unsigned NUM_GROUPS   = 9,
    parameter int unsigned WORD_W       = 11
) (
    input  logic [ADDR_W-1:0]    addr,
    output addr_kind_e           kind,
    output logic [GRP_IDX_W-1:0] grp,
    output logic [WORD_W-1:0]    word
);

    localparam logic [31:0] WIN_END = 32'(WINDOW_BYTES);
    localparam logic [31:0] GRP_END = GRP_BASE + 32'(NUM_GROUPS) * GRP_STRIDE;

    logic [31:0] addr_ext;
    logic [1:0]  unused_lsb;

    assign addr_ext   = 32'(addr);
    assign unused_lsb = addr[1:0];

    // Classify the address and pull out indices.
    always_comb begin
        word = addr[WORD_W+1:2];
        grp  = addr[GRP_IDX_LSB +: GRP_IDX_W];
        kind = AK_VOID;
        if (addr_ext < WIN_END) begin
            kind = AK_PLAIN;
            if ((addr_ext >= GRP_BASE) && (addr_ext < GRP_END)) begin
                if (addr[7:2] == 6'd0) begin
                    kind = AK_ENABLE;
                end else if (addr[7:2] == 6'd1) begin
                    kind = AK_STATUS;
                end
            end
        end
    end

endmodule

// File: rtl/intc_word_store.sv
`timescale 1ns/1ps
// Plain word storage for every window location that is not a group register.
// One write port, one combinational read port; cleared by reset.
module intc_word_store
    import intc_agg_pkg::*;
#(
    parameter int unsigned WORDS  = 2048,
    parameter int unsigned WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] widx,
    input  logic [REG_W-1:0]  wdata,
    input  logic [WORD_W-1:0] ridx,
    output logic [REG_W-1:0]  rdata
);

    logic [REG_W-1:0] mem [WORDS];

    // Clear on reset, otherwise store the addressed word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(WORDS); i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Read the addressed word without side effects.
    assign rdata = mem[ridx];

    // R10: a stored word reads back on the next cycle.
    p_store_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/intc_src_rise.sv
`timescale 1ns/1ps
// Source rise detector for one group: flags a cycle in which any line is high
// that was low the cycle before. Lines are assumed synchronous to clk.
module intc_src_rise #(
    parameter int unsigned LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] src,
    output logic             trig
);

    logic [LINES-1:0] src_q;

    // Remember last cycle's source levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= src;
        end
    end

    // Any newly high line starts an evaluation.
    assign trig = |(src & ~src_q);

endmodule

// File: rtl/intc_group_ctrl.sv
`timescale 1ns/1ps
// Per-group controller: sticky enable, mask, status, deferred set and the
// group output line. Register writes are applied first; a source rise in the
// same cycle is then judged against the post-write state.
module intc_group_ctrl
    import intc_agg_pkg::*;
#(
    parameter int unsigned LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_st,
    input  logic [REG_W-1:0] wdata,
    input  logic [LINES-1:0] src,
    input  logic             trig,
    output logic [LINES-1:0] en_word,
    output logic [LINES-1:0] status,
    output logic             irq
);

    logic [LINES-1:0] en_q, enw_q, mask_q, st_q, pd_q;
    logic             irq_q;
    logic [LINES-1:0] en_n, enw_n, mask_n, st_n, pd_n;
    logic             irq_n;
    logic [LINES-1:0] wd, chg, sel;

    assign wd = wdata[LINES-1:0];

    // Next state: enable/mask write, then status write, then source evaluation.
    always_comb begin
        en_n   = en_q;
        enw_n  = enw_q;
        mask_n = mask_q;
        st_n   = st_q;
        pd_n   = pd_q;
        irq_n  = irq_q;
        chg    = enw_q ^ wd;
        sel    = '0;

        if (wr_en) begin
            if ((wd == '0) && (en_q == '0)) begin
                enw_n = wd;
            end else if ((en_q | wd) != en_q) begin
                en_n  = en_q | wd;
                enw_n = wd;
            end else begin
                if ((chg & wd) != '0) begin
                    mask_n = mask_q & ~chg;
                end else begin
                    mask_n = mask_q | chg;
                end
                enw_n = wd;
            end
        end

        if (wr_st) begin
            st_n = st_q & ~wd;
            if ((wdata != INIT_WORD) && (st_n == '0)) begin
                if (pd_q != '0) begin
                    st_n  = pd_q;
                    pd_n  = '0;
                    irq_n = 1'b1;
                end else begin
                    irq_n = 1'b0;
                end
            end
        end

        sel = src & en_n;
        if (trig && (sel != '0)) begin
            if ((mask_n != '0) || (st_n != '0)) begin
                pd_n = pd_n | sel;
            end else begin
                st_n  = sel;
                irq_n = 1'b1;
            end
        end
    end

    // State registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            enw_q  <= '0;
            mask_q <= '0;
            st_q   <= '0;
            pd_q   <= '0;
            irq_q  <= 1'b0;
        end else begin
            en_q   <= en_n;
            enw_q  <= enw_n;
            mask_q <= mask_n;
            st_q   <= st_n;
            pd_q   <= pd_n;
            irq_q  <= irq_n;
        end
    end

    assign en_word = enw_q;
    assign status  = st_q;
    assign irq     = irq_q;

    // R3: a nonzero status always has the output raised.
    p_status_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != '0) |-> irq_q);

    // R4: the deferred set moves only on a source rise or a status write.
    p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !wr_st) |=> $stable(pd_q));

    // R5: sticky enable bits are never lost.
    p_enable_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((en_q & $past(en_q)) == $past(en_q)));

    // R6: the mask changes only through an enable write.
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));

    // R8: draining status with work deferred replays it and keeps the line high.
    p_replay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && (wdata != INIT_WORD) && ((st_q & ~wd) == '0) && (pd_q != '0))
        |=> ((st_q == $past(pd_q)) && irq_q));

endmodule

// File: rtl/intc_group_agg.sv
`timescale 1ns/1ps
// Grouped interrupt aggregator top. Decodes the register port, steers writes
// to the per-group controllers or to plain storage, and muxes read data.
// Assumes full 32-bit accesses and sources synchronous to clk.
module intc_group_agg
    import intc_agg_pkg::*;
#(
    parameter int unsigned NUM_GROUPS   = 9,
    parameter int unsigned LINES        = 32,
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned WINDOW_BYTES = 32'h2000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [REG_W-1:0]            bus_wdata,
    output logic [REG_W-1:0]            bus_rdata,
    input  logic [NUM_GROUPS*LINES-1:0] src_lines,
    output logic [NUM_GROUPS-1:0]       irq_out
);

    localparam int unsigned WORDS  = WINDOW_BYTES / 4;
    localparam int unsigned WORD_W = $clog2(WORDS);

    addr_kind_e           kind;
    logic [GRP_IDX_W-1:0] grp;
    logic [WORD_W-1:0]    word;
    logic [REG_W-1:0]     store_rdata;
    logic [REG_W-1:0]     grp_en_word [NUM_GROUPS];
    logic [REG_W-1:0]     grp_status  [NUM_GROUPS];

    intc_addr_decode #(
        .ADDR_W      (ADDR_W),
        .WINDOW_BYTES(WINDOW_BYTES),
        .NUM_GROUPS  (NUM_GROUPS),
        .WORD_W      (WORD_W)
    ) u_dec (
        .addr(bus_addr),
        .kind(kind),
        .grp (grp),
        .word(word)
    );

    intc_word_store #(
        .WORDS (WORDS),
        .WORD_W(WORD_W)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bus_we && (kind == AK_PLAIN)),
        .widx (word),
        .wdata(bus_wdata),
        .ridx (word),
        .rdata(store_rdata)
    );

    // One rise detector and controller per group.
    for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_grp
        logic             trig;
        logic             hit;
        logic [LINES-1:0] enw, st;

        assign hit = (grp == GRP_IDX_W'(g));

        intc_src_rise #(.LINES(LINES)) u_rise (
            .clk  (clk),
            .rst_n(rst_n),
            .src  (src_lines[g*LINES +: LINES]),
            .trig (trig)
        );

        intc_group_ctrl #(.LINES(LINES)) u_ctrl (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_we && hit && (kind == AK_ENABLE)),
            .wr_st  (bus_we && hit && (kind == AK_STATUS)),
            .wdata  (bus_wdata),
            .src    (src_lines[g*LINES +: LINES]),
            .trig   (trig),
            .en_word(enw),
            .status (st),
            .irq    (irq_out[g])
        );

        assign grp_en_word[g] = REG_W'(enw);
        assign grp_status[g]  = REG_W'(st);
    end

    // Select read data by location kind; nothing outside the window reads back.
    always_comb begin
        unique case (kind)
            AK_ENABLE: bus_rdata = grp_en_word[grp];
            AK_STATUS: bus_rdata = grp_status[grp];
            AK_PLAIN:  bus_rdata = store_rdata;
            default:   bus_rdata = '0;
        endcase
    end

    // R11: addresses past the window always read zero.
    p_oor_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bus_addr) >= 32'(WINDOW_BYTES)) |-> (bus_rdata == '0));

    // R1: the first cycle after reset has every output line low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));

endmodule

// File: tb/sim_intc_group_agg.sv
`timescale 1ns/1ps
module sim_intc_group_agg;

    localparam int NG = 9;
    localparam int NL = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_we = 1'b0;
    logic [15:0]      bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NG*NL-1:0] src_lines = '0;
    logic [NG-1:0]    irq_out;

    logic [NG*NL-1:0] src_v = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    intc_group_agg u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lines(src_lines),
        .irq_out(irq_out)
    );

    // Reference state built from the requirements.
    logic [31:0]      m_enr [NG];
    logic [31:0]      m_en  [NG];
    logic [31:0]      m_msk [NG];
    logic [31:0]      m_st  [NG];
    logic [31:0]      m_pd  [NG];
    logic [NG-1:0]    m_irq;
    logic [NG*NL-1:0] m_srcq;
    logic [31:0]      m_mem [2048];

    function automatic bit is_grp_reg(input logic [15:0] a);
        return (a >= 16'h1000) && (a < 16'h1000 + 16'(NG) * 16'h100) &&
               (((a & 16'h00FC) == 0) || ((a & 16'h00FC) == 4));
    endfunction

    function automatic logic [31:0] m_read(input logic [15:0] a);
        int g;
        if (a >= 16'h2000) return 32'h0;
        if (is_grp_reg(a)) begin
            g = int'(a[11:8]);
            if ((a & 16'h00FC) == 0) return m_enr[g];
            return m_st[g];
        end
        return m_mem[a[12:2]];
    endfunction

    task automatic m_step(input logic we, input logic [15:0] a, input logic [31:0] d);
        for (int g = 0; g < NG; g++) begin
            logic [31:0] lines, old, sel, chg;
            bit hit;
            hit = we && is_grp_reg(a) && (int'(a[11:8]) == g);
            if (hit && ((a & 16'h00FC) == 0)) begin
                if (d == 0 && m_en[g] == 0) m_enr[g] = d;
                else if ((m_en[g] | d) != m_en[g]) begin
                    m_en[g] = m_en[g] | d; m_enr[g] = d;
                end else begin
                    chg = m_enr[g] ^ d;
                    if ((chg & d) != 0) m_msk[g] = m_msk[g] & ~chg;
                    else m_msk[g] = m_msk[g] | chg;
                    m_enr[g] = d;
                end
            end
            if (hit && ((a & 16'h00FC) == 4)) begin
                m_st[g] = m_st[g] & ~d;
                if (d != 32'hFFFF_FFFF && m_st[g] == 0) begin
                    if (m_pd[g] != 0) begin
                        m_st[g] = m_pd[g]; m_pd[g] = 0; m_irq[g] = 1'b1;
                    end else m_irq[g] = 1'b0;
                end
            end
            lines = src_v[g*NL +: NL];
            old   = m_srcq[g*NL +: NL];
            sel   = lines & m_en[g];
            if (((lines & ~old) != 0) && sel != 0) begin
                if (m_msk[g] != 0 || m_st[g] != 0) m_pd[g] = m_pd[g] | sel;
                else begin m_st[g] = sel; m_irq[g] = 1'b1; end
            end
        end
        if (we && a < 16'h2000 && !is_grp_reg(a)) m_mem[a[12:2]] = d;
        m_srcq = src_v;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, return at the next falling edge.
    task automatic step(input logic we, input logic [15:0] a, input logic [31:0] d);
        bus_we = we; bus_addr = a; bus_wdata = d; src_lines = src_v;
        m_step(we, a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        step(1'b1, a, d);
    endtask

    task automatic idle();
        step(1'b0, 16'h0000, 32'h0);
    endtask

    task automatic rd(input string req, input logic [15:0] a, input logic [31:0] exp);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int g = 0; g < NG; g++) begin
            m_enr[g] = 0; m_en[g] = 0; m_msk[g] = 0; m_st[g] = 0; m_pd[g] = 0;
        end
        for (int i = 0; i < 2048; i++) m_mem[i] = 0;
        m_irq = '0; m_srcq = '0;
        void'($urandom(32'h5EED));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", 32'(irq_out), 32'h0);
        rd("R1 en0", 16'h1000, 32'h0);
        rd("R1 st0", 16'h1004, 32'h0);
        rd("R1 st8", 16'h1804, 32'h0);
        rd("R1 plain", 16'h0040, 32'h0);

        // R3/R5: enable a line, raise it, status latches
        wr(16'h1000, 32'h8);
        rd("R5 en0 stored", 16'h1000, 32'h8);
        src_v[3] = 1'b1; idle();
        rd("R3 st0 latch", 16'h1004, 32'h8);
        chk("R3 irq0", 32'(irq_out[0]), 32'h1);

        // R2: a disabled line on an idle group does nothing
        src_v[32+2] = 1'b1; idle();
        chk("R2 irq1", 32'(irq_out[1]), 32'h0);
        rd("R2 st1", 16'h1104, 32'h0);

        // R4/R8: deferral while busy, then replay on acknowledge
        wr(16'h1000, 32'h10);
        rd("R5 en0 new bits", 16'h1000, 32'h10);
        src_v[4] = 1'b1; idle();
        rd("R4 st0 held", 16'h1004, 32'h8);
        chk("R4 irq0", 32'(irq_out[0]), 32'h1);
        wr(16'h1004, 32'h8);
        rd("R8 replay", 16'h1004, 32'h18);
        chk("R8 irq0 high", 32'(irq_out[0]), 32'h1);
        src_v[3] = 1'b0; src_v[4] = 1'b0; idle();
        wr(16'h1004, 32'h18);
        chk("R8 irq0 low", 32'(irq_out[0]), 32'h0);

        // R6: mask by rewriting enable, defer, unmask, replay by status write
        wr(16'h1200, 32'h3);
        wr(16'h1200, 32'h1);
        rd("R6 en2 word", 16'h1200, 32'h1);
        src_v[64] = 1'b1; idle();
        chk("R6 masked irq2", 32'(irq_out[2]), 32'h0);
        rd("R6 masked st2", 16'h1204, 32'h0);
        wr(16'h1200, 32'h3);
        chk("R6 unmask no replay", 32'(irq_out[2]), 32'h0);
        wr(16'h1204, 32'h0);
        rd("R8 st2 replay", 16'h1204, 32'h1);
        chk("R8 irq2", 32'(irq_out[2]), 32'h1);

        // R7: all-ones write clears only
        src_v[65] = 1'b1; idle();
        wr(16'h1204, 32'hFFFF_FFFF);
        rd("R7 st2 cleared", 16'h1204, 32'h0);
        chk("R7 irq2 kept", 32'(irq_out[2]), 32'h1);
        wr(16'h1204, 32'h0);
        rd("R7 pending kept", 16'h1204, 32'h3);
        src_v[64] = 1'b0; src_v[65] = 1'b0; idle();
        wr(16'h1204, 32'h3);
        chk("R8 irq2 low", 32'(irq_out[2]), 32'h0);

        // R5: sticky enable survives a zero write
        wr(16'h1300, 32'h5);
        wr(16'h1300, 32'h0);
        rd("R5 en3 reads zero", 16'h1300, 32'h0);
        src_v[96] = 1'b1; idle();
        chk("R5 irq3 masked", 32'(irq_out[3]), 32'h0);
        wr(16'h1300, 32'h5);
        wr(16'h1304, 32'h0);
        rd("R5 sticky line replayed", 16'h1304, 32'h1);

        // R12: all-ones write and a rise in the same cycle
        wr(16'h1400, 32'h3);
        src_v[128] = 1'b1; idle();
        src_v[129] = 1'b1;
        wr(16'h1404, 32'hFFFF_FFFF);
        rd("R12 write first", 16'h1404, 32'h3);
        rd("R10 read no side effect", 16'h1404, 32'h3);
        chk("R12 irq4", 32'(irq_out[4]), 32'h1);

        // R10: plain storage
        wr(16'h0040, 32'hDEAD_BEEF);
        rd("R10 plain low", 16'h0040, 32'hDEAD_BEEF);
        wr(16'h1008, 32'h0000_1234);
        rd("R10 group gap", 16'h1008, 32'h0000_1234);
        wr(16'h1900, 32'h0000_A5A5);
        rd("R10 unused group slot", 16'h1900, 32'h0000_A5A5);
        rd("R10 en0 untouched", 16'h1000, 32'h10);

        // R11: out of window
        wr(16'h2000, 32'h55);
        rd("R11 oor read", 16'h2000, 32'h0);
        rd("R11 no alias", 16'h0000, 32'h0);
        rd("R11 top read", 16'hFFFC, 32'h0);

        // R9: last group
        wr(16'h1800, 32'h1);
        src_v[256] = 1'b1; idle();
        chk("R9 irq vector", 32'(irq_out), 32'h118);
        rd("R9 st8", 16'h1804, 32'h1);

        // Random traffic against the reference state
        for (int n = 0; n < 3000; n++) begin
            int r, g, c;
            logic [31:0] d;
            logic [15:0] a;
            r = int'($urandom % 10);
            g = int'($urandom % NG);
            c = int'($urandom % 4);
            if (r < 3) begin
                case (c)
                    0: d = 32'h1 << ($urandom % 6);
                    1: d = m_enr[g] ^ (32'h1 << ($urandom % 6));
                    2: d = m_en[g];
                    default: d = 32'h0;
                endcase
                wr(16'h1000 + 16'(g) * 16'h100, d);
            end else if (r < 5) begin
                case (c)
                    0: d = m_st[g];
                    1: d = m_st[g] & $urandom;
                    2: d = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : 32'h0;
                    default: d = 32'h0;
                endcase
                wr(16'h1004 + 16'(g) * 16'h100, d);
            end else if (r == 5) begin
                a = (c == 0) ? 16'(32'h2000 + ($urandom % 32'h400)) : 16'($urandom % 32'h2000);
                wr(a & 16'hFFFC, $urandom);
            end else begin
                if (c == 0) src_v[g*NL +: NL] = '0;
                else src_v[g*NL + int'($urandom % 6)] = ~src_v[g*NL + int'($urandom % 6)];
                idle();
            end
            chk("R2-R8 irq random", 32'(irq_out), 32'(m_irq));
            c = int'($urandom % 4);
            g = int'($urandom % NG);
            case (c)
                0: a = 16'h1000 + 16'(g) * 16'h100;
                1: a = 16'h1004 + 16'(g) * 16'h100;
                2: a = 16'($urandom % 32'h2000) & 16'hFFFC;
                default: a = 16'($urandom) & 16'hFFFC;
            endcase
            rd("R9 R10 R11 read random", a, m_read(a));
        end

        finish_run();
    end

endmodule